// File: doc/BRIEF.md
# Multi-Core Idle-State Resolution Arbiter

This block takes idle-state requests from every hardware thread of a multi-core die and turns them into one resolved idle state per core and one for the whole package. A thread asks for sleep in one of three ways: an instruction hint carrying a state code, a halt, or a legacy read of one of two per-level I/O ports. The request of one thread never acts alone. Each core takes the shallowest state requested by its threads, and the package follows the shallowest state among the cores.

Before the package goes to a deep state (C3 or C6), the block asks the platform for permission with a request/grant handshake. The package only moves once the grant has arrived. A wake event on any thread sends that thread, its core and the package back to C0 and drops the permission request. The block only makes decisions and runs the handshake. Power switching, clock control and voltage control are handled elsewhere.

State codes are 3 bits wide: C0=0, C1=1, C1E=2, C3=3, C6=4. Every port is a plain control or status pin, so there is no back-pressure.

Top module: `idle_resolve_top`

## Requirements
- R1: A hint request (source code 0) stores hint codes 0, 1, 3 and 4 unchanged. Hint code 2 (C1E) is stored as C1E when `c1e_en` is 1 and as C1 when it is 0. The stored state is visible the cycle after the request edge.
- R2: A halt request (source code 1) stores C1E when `c1e_en` is 1 and C1 otherwise.
- R3: A read of the level-2 port (source code 2) stores C3. A read of the level-3 port (source code 3) stores C6.
- R4: A hint request with code 5, 6 or 7 is ignored, and the thread keeps its previous state.
- R5: Each core state is the minimum of its threads' stored states, ordered C0 < C1 < C1E < C3 < C6. Thread t belongs to core t / THREADS_PER_CORE. Core c occupies bits [3c+2:3c] of `core_state`.
- R6: When the minimum over all cores is below C3, the package is C0 and `plat_req` is low from the next cycle on.
- R7: When the minimum over all cores is C3 or C6 and differs from the package state, `plat_req` rises on the next cycle. It stays high until a grant is sampled or the minimum stops being deep.
- R8: On an edge where both `plat_req` and `plat_grant` are high, the package takes the deep target (C3 if the minimum is C3, C6 only if every core is C6) and `plat_req` drops.
- R9: If the minimum leaves the deep range before a grant, `plat_req` drops on the next cycle, and a later grant leaves the package in C0.
- R10: A wake on a thread forces that thread to C0 on the next cycle, even when a request arrives in the same cycle. Any wake forces the package to C0 and `plat_req` low on the next cycle.
- R11: If the package is deep and the target changes to a different deep state, the package returns to C0 and requests permission again before entering the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c1e_en | input | 1 | Enables the enhanced C1 variant |
| thr_req_vld | input | NT | One request pulse per thread |
| thr_req_src | input | 2*NT | Per-thread source: 0 hint, 1 halt, 2 level-2 port, 3 level-3 port |
| thr_req_hint | input | 3*NT | Per-thread hint state code |
| thr_wake | input | NT | Per-thread wake event |
| plat_grant | input | 1 | Platform permission grant |
| core_state | output | 3*NC | Resolved state of each core |
| pkg_state | output | 3 | Resolved package state |
| plat_req | output | 1 | Permission request to the platform |

## Verification
The assertions check these rules on every cycle:
- a wake always clears the thread and the package on the next cycle;
- a rejected hint leaves the thread state stable;
- no core is deeper than any of its threads;
- the package never enters a deep state without a granted request;
- a pending request stays up while the target is still deep.

The bench scenarios cover what depends on ordering:
- the arithmetic minimum over a sweep of thread-state patterns;
- the C1E mapping under both settings of the enable;
- abandoning entry before a grant;
- retargeting from C3 to C6;
- a wake that collides with a request.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
  localparam int CSW = 3;
  localparam logic [2:0] CS_C0  = 3'd0;
  localparam logic [2:0] CS_C1  = 3'd1;
  localparam logic [2:0] CS_C1E = 3'd2;
  localparam logic [2:0] CS_C3  = 3'd3;
  localparam logic [2:0] CS_C6  = 3'd4;

  localparam logic [1:0] SRC_HINT  = 2'd0;
  localparam logic [1:0] SRC_HALT  = 2'd1;
  localparam logic [1:0] SRC_PORT2 = 2'd2;
  localparam logic [1:0] SRC_PORT3 = 2'd3;

  function automatic logic is_deep(input logic [2:0] s);
    return (s == CS_C3) || (s == CS_C6);
  endfunction
endpackage

// File: rtl/idle_thread_slot.sv
module idle_thread_slot
  import idle_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       c1e_en,
  input  logic       req_vld,
  input  logic [1:0] req_src,
  input  logic [2:0] req_hint,
  input  logic       wake,
  output logic [2:0] state
);
  logic       dec_ok;
  logic [2:0] dec_st;

  // Translate the request source into a state code
  always_comb begin
    dec_ok = 1'b1;
    dec_st = CS_C0;
    case (req_src)
      SRC_HINT: begin
        if (req_hint > CS_C6)                     dec_ok = 1'b0;
        else if (req_hint == CS_C1E && !c1e_en)   dec_st = CS_C1;
        else                                      dec_st = req_hint;
      end
      SRC_HALT:  dec_st = c1e_en ? CS_C1E : CS_C1;
      SRC_PORT2: dec_st = CS_C3;
      default:   dec_st = CS_C6;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                state <= CS_C0;
    else if (wake)             state <= CS_C0;
    else if (req_vld && dec_ok) state <= dec_st;
  end

  a_r10_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> state == CS_C0);
  a_r4_bad_hint_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_src == SRC_HINT && req_hint > CS_C6 && !wake) |=> $stable(state));
  a_r3_port3_c6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_src == SRC_PORT3 && !wake) |=> state == CS_C6);
endmodule

// File: rtl/idle_min_reduce.sv
module idle_min_reduce #(
  parameter int N = 2
) (
  input  logic [3*N-1:0] states,
  output logic [2:0]     min_state
);
  logic [2:0] stage [N];

  // Linear compare chain: stage[i] is the minimum of entries 0..i
  assign stage[0] = states[2:0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign stage[i] = (states[3*i +: 3] < stage[i-1]) ? states[3*i +: 3] : stage[i-1];
  end
  assign min_state = stage[N-1];
endmodule

// File: rtl/idle_pkg_ctrl.sv
module idle_pkg_ctrl
  import idle_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] target,
  input  logic       wake_any,
  input  logic       plat_grant,
  output logic [2:0] pkg_state,
  output logic       plat_req
);
  logic tgt_deep;
  assign tgt_deep = is_deep(target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkg_state <= CS_C0;
      plat_req  <= 1'b0;
    end else if (wake_any || !tgt_deep) begin
      pkg_state <= CS_C0;
      plat_req  <= 1'b0;
    end else if (pkg_state == target) begin
      plat_req  <= 1'b0;
    end else if (plat_req && plat_grant) begin
      pkg_state <= target;
      plat_req  <= 1'b0;
    end else begin
      pkg_state <= CS_C0;
      plat_req  <= 1'b1;
    end
  end

  a_r8_entry_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pkg_state) && pkg_state != CS_C0) |-> $past(plat_req && plat_grant));
  a_r10_wake_pkg_c0: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> (pkg_state == CS_C0 && !plat_req));
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (plat_req && !plat_grant && tgt_deep && !wake_any) |=> plat_req);
  a_r6_shallow_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_deep) |=> (pkg_state == CS_C0 && !plat_req));
endmodule

// File: rtl/idle_resolve_top.sv
module idle_resolve_top
  import idle_res_pkg::*;
#(
  parameter int NUM_CORES        = 4,
  parameter int THREADS_PER_CORE = 2,
  localparam int NT              = NUM_CORES * THREADS_PER_CORE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   c1e_en,
  input  logic [NT-1:0]          thr_req_vld,
  input  logic [2*NT-1:0]        thr_req_src,
  input  logic [3*NT-1:0]        thr_req_hint,
  input  logic [NT-1:0]          thr_wake,
  input  logic                   plat_grant,
  output logic [3*NUM_CORES-1:0] core_state,
  output logic [2:0]             pkg_state,
  output logic                   plat_req
);
  logic [3*NT-1:0] thr_st;
  logic [2:0]      pkg_target;
  logic            wake_any;

  assign wake_any = |thr_wake;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    idle_thread_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .c1e_en   (c1e_en),
      .req_vld  (thr_req_vld[t]),
      .req_src  (thr_req_src[2*t +: 2]),
      .req_hint (thr_req_hint[3*t +: 3]),
      .wake     (thr_wake[t]),
      .state    (thr_st[3*t +: 3])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    idle_min_reduce #(.N(THREADS_PER_CORE)) u_core_min (
      .states    (thr_st[3*THREADS_PER_CORE*c +: 3*THREADS_PER_CORE]),
      .min_state (core_state[3*c +: 3])
    );
    for (genvar k = 0; k < THREADS_PER_CORE; k++) begin : g_chk
      a_r5_core_not_deeper: assert property (@(posedge clk) disable iff (!rst_n)
        core_state[3*c +: 3] <= thr_st[3*(c*THREADS_PER_CORE+k) +: 3]);
    end
  end

  idle_min_reduce #(.N(NUM_CORES)) u_pkg_min (
    .states    (core_state),
    .min_state (pkg_target)
  );

  idle_pkg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .target     (pkg_target),
    .wake_any   (wake_any),
    .plat_grant (plat_grant),
    .pkg_state  (pkg_state),
    .plat_req   (plat_req)
  );
endmodule

// File: tb/tb_idle_resolve_top.sv
module tb_idle_resolve_top;
  localparam int NC  = 4;
  localparam int TPC = 2;
  localparam int NT  = NC * TPC;

  logic clk = 0, rst_n = 0, c1e_en = 0, plat_grant = 0;
  logic [NT-1:0]   vld = '0, wake = '0;
  logic [2*NT-1:0] src = '0;
  logic [3*NT-1:0] hint = '0;
  logic [3*NC-1:0] core_state;
  logic [2:0]      pkg_state;
  logic            plat_req;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  idle_resolve_top #(.NUM_CORES(NC), .THREADS_PER_CORE(TPC)) dut (
    .clk(clk), .rst_n(rst_n), .c1e_en(c1e_en), .thr_req_vld(vld),
    .thr_req_src(src), .thr_req_hint(hint), .thr_wake(wake),
    .plat_grant(plat_grant), .core_state(core_state),
    .pkg_state(pkg_state), .plat_req(plat_req));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int core_of(int c);
    return int'(core_state[3*c +: 3]);
  endfunction

  function automatic int deep(int s);
    return (s == 3 || s == 4) ? 1 : 0;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Same request on every thread of one core, one cycle
  task automatic req_core(int c, int s, int h);
    for (int k = 0; k < TPC; k++) begin
      int t = c*TPC + k;
      vld[t] = 1'b1; src[2*t +: 2] = 2'(s); hint[3*t +: 3] = 3'(h);
    end
    step();
    vld = '0;
  endtask

  task automatic req_all(int s, int h);
    for (int t = 0; t < NT; t++) begin
      vld[t] = 1'b1; src[2*t +: 2] = 2'(s); hint[3*t +: 3] = 3'(h);
    end
    step();
    vld = '0;
  endtask

  task automatic wake_all();
    wake = '1;
    step();
    wake = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // reset state
    for (int c = 0; c < NC; c++) chk("R5 reset core", core_of(c), 0);
    chk("R6 reset pkg", pkg_state, 0);
    chk("R6 reset req", plat_req, 0);

    // decode paths
    c1e_en = 0;
    req_core(0, 0, 2); chk("R1 hint C1E disabled -> C1", core_of(0), 1);
    req_core(0, 0, 3); chk("R1 hint C3", core_of(0), 3);
    req_core(1, 1, 0); chk("R2 halt c1e off", core_of(1), 1);
    c1e_en = 1;
    req_core(1, 1, 0); chk("R2 halt c1e on", core_of(1), 2);
    req_core(2, 0, 2); chk("R1 hint C1E enabled", core_of(2), 2);
    req_core(2, 2, 0); chk("R3 level-2 port", core_of(2), 3);
    req_core(3, 3, 0); chk("R3 level-3 port", core_of(3), 4);
    // R4: bad hint on thread 0 while core 0 sits in C3
    vld[0] = 1; src[1:0] = 2'd0; hint[2:0] = 3'd6;
    step(); vld = '0;
    chk("R4 bad hint ignored", core_of(0), 3);
    step();
    chk("R6 shallow min keeps pkg", pkg_state, 0);
    chk("R6 shallow min no req", plat_req, 0);

    wake_all();
    chk("R10 wake clears core", core_of(2), 0);
    chk("R10 wake pkg", pkg_state, 0);

    // deep entry into C3 with delayed grant
    plat_grant = 0;
    req_all(2, 0);
    step();
    chk("R7 req raised", plat_req, 1);
    repeat (3) step();
    chk("R7 req held", plat_req, 1);
    chk("R7 pkg waits", pkg_state, 0);
    plat_grant = 1;
    step();
    chk("R8 entry C3", pkg_state, 3);
    chk("R8 req dropped", plat_req, 0);
    plat_grant = 0;

    // retarget C3 -> C6
    req_all(3, 0);
    step();
    chk("R11 retarget pkg C0", pkg_state, 0);
    chk("R11 retarget re-request", plat_req, 1);
    plat_grant = 1;
    step();
    chk("R8 entry C6", pkg_state, 4);
    plat_grant = 0;

    // abandon before grant
    wake_all();
    req_all(2, 0);
    step();
    chk("R7 req before abandon", plat_req, 1);
    vld[0] = 1; src[1:0] = 2'd0; hint[2:0] = 3'd1;
    step(); vld = '0;
    step();
    chk("R9 req dropped", plat_req, 0);
    plat_grant = 1;
    step();
    chk("R9 late grant ignored", pkg_state, 0);
    plat_grant = 0;

    // wake colliding with request on thread 3
    vld[3] = 1; src[7:6] = 2'd0; hint[11:9] = 3'd4; wake[3] = 1;
    step(); vld = '0; wake = '0;
    chk("R10 wake beats request", core_of(1), 0);

    // wake from deep package
    req_all(2, 0);
    plat_grant = 1;
    step(); step();
    chk("R8 entry C3 again", pkg_state, 3);
    plat_grant = 0;
    wake[5] = 1; step(); wake = '0;
    chk("R10 wake exits deep", pkg_state, 0);
    chk("R10 wake drops req", plat_req, 0);
    chk("R10 wake core", core_of(2), 0);

    // sweep of thread-state patterns with grant held
    wake_all();
    c1e_en = 1;
    plat_grant = 1;
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        int cexp [NC];
        int tgt;
        tgt = 9;
        for (int c = 0; c < NC; c++) begin
          int v0, v1;
          v0 = (a + c) % 5;
          v1 = (b + 2*c) % 5;
          cexp[c] = (v0 < v1) ? v0 : v1;
          if (cexp[c] < tgt) tgt = cexp[c];
          vld[c*TPC] = 1; src[2*c*TPC +: 2] = 2'd0; hint[3*c*TPC +: 3] = 3'(v0);
          vld[c*TPC+1] = 1; src[2*(c*TPC+1) +: 2] = 2'd0; hint[3*(c*TPC+1) +: 3] = 3'(v1);
        end
        step(); vld = '0;
        for (int c = 0; c < NC; c++) chk("R5 sweep core min", core_of(c), cexp[c]);
        step();
        chk("R7 sweep req", plat_req, deep(tgt));
        step();
        chk("R8 sweep pkg", pkg_state, deep(tgt) ? tgt : 0);
        chk("R8 sweep req low", plat_req, 0);
        wake_all();
        chk("R10 sweep wake", pkg_state, 0);
      end
    end
    plat_grant = 0;
    finish_run();
  end
endmodule